// File: doc/BRIEF.md
# Paged Address Translation Map

This block maps a 24-bit address issued by a network controller, or by the host on the controller's behalf, onto a local buffer-memory address. It uses a table of 1024 page descriptors held in registers. Address bits 23:20 are discarded. Bits 19:10 pick a descriptor, and bits 9:0 are carried through as the byte position inside a 1 KB page. The chosen descriptor supplies three things: the physical page number, a byte-order choice that decides whether the two bytes of each 16-bit word trade places on the data path, and a choice between on-board memory and memory on the external secondary bus.

The host loads and inspects descriptors through a simple indexed port. Translation requests carry a tag naming the requester, a flag for byte or word width, and the write data. One clock later the block returns the physical address, the routing and order flags, the byte-lane enables and the lane-corrected write data. Because the controller expects its configuration pointer at 0xFFFFF4, descriptor 1023 must always point at the page that holds that structure.

Top module: `pagemap_xlate`

## Requirements
- R1: After reset every descriptor reads as 0x0000 and `out_valid` is low. A translation through an untouched descriptor therefore yields page 0, on-board routing and exchanged byte order.
- R2: A request with `xl_valid` high produces `out_valid` high exactly one cycle later, with `out_host` equal to the request's `xl_host`. A cycle without a request produces `out_valid` low one cycle later. Requests from the controller (`xl_host`=0) and from the host (`xl_host`=1) are translated identically.
- R3: Address bits 23:20 have no effect on any translation output.
- R4: Address bits 19:10 select the descriptor, and `out_addr[9:0]` equals address bits 9:0.
- R5: `out_addr[17:10]` equals descriptor bits 7:0. Descriptor bits 11:8 have no effect, because only 256 pages exist.
- R6: When descriptor bit 15 is 1 (big-endian), `out_swap` is 0 and `out_wdata` equals `xl_wdata`. When it is 0 (little-endian), `out_swap` is 1 and `out_wdata` is `xl_wdata` with bits 15:8 and 7:0 exchanged.
- R7: `out_ext` equals descriptor bit 13: 1 routes the access to the external secondary bus, 0 routes it to on-board memory.
- R8: A descriptor write (`map_we`=1) takes effect at the next clock edge. A translation presented in the same cycle as a write to its descriptor uses the old value. `map_rdata` returns the full 16-bit descriptor at `map_idx`, one cycle after the index is presented.
- R9: In `out_lane`, bit 1 enables data bits 15:8 and bit 0 enables bits 7:0. A word access enables both lanes. A byte access enables one lane. With big-endian order, an even address selects lane 1 and an odd address selects lane 0. With little-endian order, an even address selects lane 0 and an odd address selects lane 1.
- R10: Address 0xFFFFF4 is translated through descriptor 1023 and gives page offset 0x3F4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_we | input | 1 | Descriptor write strobe |
| map_idx | input | 10 | Descriptor index for write and read |
| map_wdata | input | 16 | Descriptor value to write |
| map_rdata | output | 16 | Registered descriptor read value |
| xl_valid | input | 1 | Translation request |
| xl_host | input | 1 | Requester tag: 0 controller, 1 host |
| xl_byte | input | 1 | 1 for a byte access, 0 for a word access |
| xl_addr | input | 24 | Address to translate |
| xl_wdata | input | 16 | Write data of the access |
| out_valid | output | 1 | Translation result valid |
| out_host | output | 1 | Requester tag of the result |
| out_addr | output | 18 | Physical page and offset |
| out_ext | output | 1 | 1 routes the access to external-bus memory |
| out_swap | output | 1 | 1 when the bytes of each word are exchanged |
| out_lane | output | 2 | Byte-lane enables |
| out_wdata | output | 16 | Write data after lane correction |

## Verification
Every cycle, the assertions check the one-cycle request-to-result timing, that the tag is carried through, that the page offset passes through, that word and byte lane counts are right, that the write data matches the reported order flag, and that a descriptor reads back after it is written. Other behaviours depend on descriptor contents chosen by the scenarios, so only the bench's scenarios can show them: that the top address nibble and the upper frame bits are ignored, which lane a byte lands in, the old-value result when a write and a lookup collide, and the use of descriptor 1023 for the configuration pointer.

// File: rtl/pagemap_pkg.sv
package pagemap_pkg;

   // Byte order chosen by a page descriptor
   typedef enum logic {
      ORD_LITTLE = 1'b0,
      ORD_BIG    = 1'b1
   } order_e;

   // Default geometry shared by the block and its checker
   localparam int unsigned DEF_ADDR_W   = 24;
   localparam int unsigned DEF_IGNORE_W = 4;
   localparam int unsigned DEF_OFFS_W   = 10;
   localparam int unsigned DEF_ENTRY_W  = 16;
   localparam int unsigned DEF_PFN_W    = 12;
   localparam int unsigned DEF_PAGES    = 256;
   localparam int unsigned DEF_ORD_BIT  = 15;
   localparam int unsigned DEF_BUS_BIT  = 13;
   localparam int unsigned DEF_LANES    = 2;
   localparam int unsigned DEF_BYTE_W   = 8;

endpackage

// File: rtl/pagemap_store.sv
module pagemap_store #(
   parameter int unsigned IDX_W   = 10,
   parameter int unsigned ENTRY_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [IDX_W-1:0]   host_idx,
   input  logic [ENTRY_W-1:0] wdata,
   output logic [ENTRY_W-1:0] rdata,
   input  logic [IDX_W-1:0]   look_idx,
   output logic [ENTRY_W-1:0] look_entry
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   logic [ENTRY_W-1:0] desc_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            desc_q[i] <= '0;
         end
      end else if (we) begin
         desc_q[host_idx] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else begin
         rdata <= desc_q[host_idx];
      end
   end

   assign look_entry = desc_q[look_idx];

endmodule

// File: rtl/pagemap_lookup.sv
module pagemap_lookup
   import pagemap_pkg::*;
#(
   parameter int unsigned ADDR_W   = 24,
   parameter int unsigned IGNORE_W = 4,
   parameter int unsigned OFFS_W   = 10,
   parameter int unsigned ENTRY_W  = 16,
   parameter int unsigned PAGE_W   = 8,
   parameter int unsigned ORD_BIT  = 15,
   parameter int unsigned BUS_BIT  = 13,
   localparam int unsigned IDX_W   = ADDR_W - IGNORE_W - OFFS_W
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic [ENTRY_W-1:0] entry,
   output logic [IDX_W-1:0]   idx,
   output logic [OFFS_W-1:0]  offs,
   output logic [PAGE_W-1:0]  page,
   output order_e             order,
   output logic               ext
);
   // Split the address: the ignored top field is dropped here
   assign idx  = addr[OFFS_W +: IDX_W];
   assign offs = addr[OFFS_W-1:0];

   // Decode the selected descriptor
   assign page  = entry[PAGE_W-1:0];
   assign order = entry[ORD_BIT] ? ORD_BIG : ORD_LITTLE;
   assign ext   = entry[BUS_BIT];

   logic unused_bits;
   assign unused_bits = ^{addr[ADDR_W-1 -: IGNORE_W], entry};

endmodule

// File: rtl/pagemap_lane.sv
module pagemap_lane
   import pagemap_pkg::*;
#(
   parameter int unsigned LANES  = 2,
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned DATA_W = LANES * BYTE_W,
   localparam int unsigned LSEL_W = $clog2(LANES)
) (
   input  order_e            order,
   input  logic              byte_acc,
   input  logic [LSEL_W-1:0] lsel,
   input  logic [DATA_W-1:0] din,
   output logic [LANES-1:0]  lane,
   output logic [DATA_W-1:0] dout
);
   logic [LSEL_W-1:0] pick;

   // Big-endian puts the lowest address in the most significant lane
   assign pick = (order == ORD_BIG) ? (LSEL_W'(LANES - 1) - lsel) : lsel;

   always_comb begin
      lane = '0;
      if (!byte_acc) begin
         lane = '1;
      end else begin
         lane[pick] = 1'b1;
      end
   end

   // Byte reversal of the word for little-endian pages
   for (genvar g = 0; g < LANES; g++) begin : g_byte
      assign dout[g*BYTE_W +: BYTE_W] = (order == ORD_LITTLE)
                                        ? din[(LANES-1-g)*BYTE_W +: BYTE_W]
                                        : din[g*BYTE_W +: BYTE_W];
   end

endmodule

// File: rtl/pagemap_xlate.sv
module pagemap_xlate
   import pagemap_pkg::*;
#(
   parameter int unsigned ADDR_W   = DEF_ADDR_W,
   parameter int unsigned IGNORE_W = DEF_IGNORE_W,
   parameter int unsigned OFFS_W   = DEF_OFFS_W,
   parameter int unsigned ENTRY_W  = DEF_ENTRY_W,
   parameter int unsigned PFN_W    = DEF_PFN_W,
   parameter int unsigned PAGES    = DEF_PAGES,
   parameter int unsigned ORD_BIT  = DEF_ORD_BIT,
   parameter int unsigned BUS_BIT  = DEF_BUS_BIT,
   parameter int unsigned LANES    = DEF_LANES,
   parameter int unsigned BYTE_W   = DEF_BYTE_W,
   localparam int unsigned IDX_W   = ADDR_W - IGNORE_W - OFFS_W,
   localparam int unsigned PAGE_W  = $clog2(PAGES),
   localparam int unsigned PHYS_W  = PAGE_W + OFFS_W,
   localparam int unsigned DATA_W  = LANES * BYTE_W,
   localparam int unsigned LSEL_W  = $clog2(LANES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               map_we,
   input  logic [IDX_W-1:0]   map_idx,
   input  logic [ENTRY_W-1:0] map_wdata,
   output logic [ENTRY_W-1:0] map_rdata,
   input  logic               xl_valid,
   input  logic               xl_host,
   input  logic               xl_byte,
   input  logic [ADDR_W-1:0]  xl_addr,
   input  logic [DATA_W-1:0]  xl_wdata,
   output logic               out_valid,
   output logic               out_host,
   output logic [PHYS_W-1:0]  out_addr,
   output logic               out_ext,
   output logic               out_swap,
   output logic [LANES-1:0]   out_lane,
   output logic [DATA_W-1:0]  out_wdata
);
   // Elaboration-time parameter checks
   if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
      $error("pagemap_xlate: index width out of range");
   end
   if (PAGE_W > PFN_W) begin : g_bad_pfn
      $error("pagemap_xlate: frame field narrower than page count");
   end
   if (PFN_W > ENTRY_W || ORD_BIT >= ENTRY_W || BUS_BIT >= ENTRY_W) begin : g_bad_entry
      $error("pagemap_xlate: descriptor fields outside entry");
   end
   if (ORD_BIT < PFN_W || BUS_BIT < PFN_W || ORD_BIT == BUS_BIT) begin : g_bad_flags
      $error("pagemap_xlate: flag bits overlap frame field");
   end
   if (LANES < 2 || (1 << LSEL_W) != LANES || LSEL_W > OFFS_W) begin : g_bad_lanes
      $error("pagemap_xlate: lane count must be a power of two");
   end

   logic [IDX_W-1:0]   look_idx;
   logic [OFFS_W-1:0]  look_offs;
   logic [ENTRY_W-1:0] look_entry;
   logic [PAGE_W-1:0]  look_page;
   order_e             look_order;
   logic               look_ext;
   logic [LANES-1:0]   look_lane;
   logic [DATA_W-1:0]  look_wdata;

   pagemap_store #(
      .IDX_W   (IDX_W),
      .ENTRY_W (ENTRY_W)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (map_we),
      .host_idx   (map_idx),
      .wdata      (map_wdata),
      .rdata      (map_rdata),
      .look_idx   (look_idx),
      .look_entry (look_entry)
   );

   pagemap_lookup #(
      .ADDR_W   (ADDR_W),
      .IGNORE_W (IGNORE_W),
      .OFFS_W   (OFFS_W),
      .ENTRY_W  (ENTRY_W),
      .PAGE_W   (PAGE_W),
      .ORD_BIT  (ORD_BIT),
      .BUS_BIT  (BUS_BIT)
   ) u_lookup (
      .addr  (xl_addr),
      .entry (look_entry),
      .idx   (look_idx),
      .offs  (look_offs),
      .page  (look_page),
      .order (look_order),
      .ext   (look_ext)
   );

   pagemap_lane #(
      .LANES  (LANES),
      .BYTE_W (BYTE_W)
   ) u_lane (
      .order    (look_order),
      .byte_acc (xl_byte),
      .lsel     (xl_addr[LSEL_W-1:0]),
      .din      (xl_wdata),
      .lane     (look_lane),
      .dout     (look_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_host  <= 1'b0;
         out_addr  <= '0;
         out_ext   <= 1'b0;
         out_swap  <= 1'b0;
         out_lane  <= '0;
         out_wdata <= '0;
      end else begin
         out_valid <= xl_valid;
         out_host  <= xl_host;
         out_addr  <= {look_page, look_offs};
         out_ext   <= look_ext;
         out_swap  <= (look_order == ORD_LITTLE);
         out_lane  <= look_lane;
         out_wdata <= look_wdata;
      end
   end

endmodule

// File: rtl/pagemap_xlate_chk.sv
module pagemap_xlate_chk #(
   parameter int unsigned IDX_W   = 10,
   parameter int unsigned ENTRY_W = 16,
   parameter int unsigned ADDR_W  = 24,
   parameter int unsigned OFFS_W  = 10,
   parameter int unsigned PHYS_W  = 18,
   parameter int unsigned LANES   = 2,
   parameter int unsigned BYTE_W  = 8,
   localparam int unsigned DATA_W = LANES * BYTE_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic               map_we,
   input logic [IDX_W-1:0]   map_idx,
   input logic [ENTRY_W-1:0] map_wdata,
   input logic [ENTRY_W-1:0] map_rdata,
   input logic               xl_valid,
   input logic               xl_host,
   input logic               xl_byte,
   input logic [ADDR_W-1:0]  xl_addr,
   input logic [DATA_W-1:0]  xl_wdata,
   input logic               out_valid,
   input logic               out_host,
   input logic [PHYS_W-1:0]  out_addr,
   input logic               out_ext,
   input logic               out_swap,
   input logic [LANES-1:0]   out_lane,
   input logic [DATA_W-1:0]  out_wdata
);
   function automatic logic [DATA_W-1:0] rev_bytes(input logic [DATA_W-1:0] d);
      logic [DATA_W-1:0] r;
      for (int k = 0; k < LANES; k++) begin
         r[k*BYTE_W +: BYTE_W] = d[(LANES-1-k)*BYTE_W +: BYTE_W];
      end
      return r;
   endfunction

   p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      xl_valid |=> out_valid);

   p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !xl_valid |=> !out_valid);

   p_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      xl_valid |=> out_host == $past(xl_host));

   p_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
      xl_valid |=> out_addr[OFFS_W-1:0] == $past(xl_addr[OFFS_W-1:0]));

   p_word_lanes_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_valid && !xl_byte) |=> out_lane == '1);

   p_byte_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_valid && xl_byte) |=> $countones(out_lane) == 1);

   p_keep_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_swap) |-> out_wdata == $past(xl_wdata));

   p_swap_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_swap) |-> out_wdata == rev_bytes($past(xl_wdata)));

   p_readback_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(map_we) && !map_we && map_idx == $past(map_idx))
      |=> map_rdata == $past(map_wdata, 2));

   logic unused_chk;
   assign unused_chk = ^{out_ext, xl_addr[ADDR_W-1:OFFS_W]};

endmodule

bind pagemap_xlate pagemap_xlate_chk #(
   .IDX_W   (IDX_W),
   .ENTRY_W (ENTRY_W),
   .ADDR_W  (ADDR_W),
   .OFFS_W  (OFFS_W),
   .PHYS_W  (PHYS_W),
   .LANES   (LANES),
   .BYTE_W  (BYTE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .map_we    (map_we),
   .map_idx   (map_idx),
   .map_wdata (map_wdata),
   .map_rdata (map_rdata),
   .xl_valid  (xl_valid),
   .xl_host   (xl_host),
   .xl_byte   (xl_byte),
   .xl_addr   (xl_addr),
   .xl_wdata  (xl_wdata),
   .out_valid (out_valid),
   .out_host  (out_host),
   .out_addr  (out_addr),
   .out_ext   (out_ext),
   .out_swap  (out_swap),
   .out_lane  (out_lane),
   .out_wdata (out_wdata)
);

// File: tb/pagemap_xlate_tb.sv
module pagemap_xlate_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        map_we = 1'b0;
   logic [9:0]  map_idx = '0;
   logic [15:0] map_wdata = '0;
   logic [15:0] map_rdata;
   logic        xl_valid = 1'b0;
   logic        xl_host = 1'b0;
   logic        xl_byte = 1'b0;
   logic [23:0] xl_addr = '0;
   logic [15:0] xl_wdata = '0;
   logic        out_valid;
   logic        out_host;
   logic [17:0] out_addr;
   logic        out_ext;
   logic        out_swap;
   logic [1:0]  out_lane;
   logic [15:0] out_wdata;

   int unsigned n_checks = 0;
   int unsigned n_bad = 0;
   logic [15:0] shadow [1024];

   always #4 clk = ~clk;  // 125 MHz

   pagemap_xlate u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .map_we    (map_we),
      .map_idx   (map_idx),
      .map_wdata (map_wdata),
      .map_rdata (map_rdata),
      .xl_valid  (xl_valid),
      .xl_host   (xl_host),
      .xl_byte   (xl_byte),
      .xl_addr   (xl_addr),
      .xl_wdata  (xl_wdata),
      .out_valid (out_valid),
      .out_host  (out_host),
      .out_addr  (out_addr),
      .out_ext   (out_ext),
      .out_swap  (out_swap),
      .out_lane  (out_lane),
      .out_wdata (out_wdata)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_lanes(input logic [15:0] ent, input logic by,
                                            input logic a0);
      if (!by) return 2'b11;
      if (ent[15]) return a0 ? 2'b01 : 2'b10;
      return a0 ? 2'b10 : 2'b01;
   endfunction

   task automatic map_write(input logic [9:0] idx, input logic [15:0] val);
      @(negedge clk);
      map_we = 1'b1; map_idx = idx; map_wdata = val;
      @(negedge clk);
      map_we = 1'b0;
      shadow[idx] = val;
   endtask

   task automatic map_read(input logic [9:0] idx, input string req);
      @(negedge clk);
      map_idx = idx;
      @(negedge clk);
      check(map_rdata == shadow[idx], req, 32'(map_rdata), 32'(shadow[idx]));
   endtask

   // Present one request, check the result one cycle later against the shadow map
   task automatic xlate(input logic [23:0] a, input logic host, input logic by,
                        input logic [15:0] wd, input string req);
      logic [15:0] ent;
      logic [17:0] ea;
      logic [15:0] ew;
      ent = shadow[a[19:10]];
      ea  = {ent[7:0], a[9:0]};
      ew  = ent[15] ? wd : {wd[7:0], wd[15:8]};
      @(negedge clk);
      xl_valid = 1'b1; xl_host = host; xl_byte = by; xl_addr = a; xl_wdata = wd;
      @(negedge clk);
      xl_valid = 1'b0;
      check(out_valid && out_host == host, req, {30'd0, out_valid, out_host}, {30'd0, 1'b1, host});
      check(out_addr == ea, req, 32'(out_addr), 32'(ea));
      check(out_swap == ~ent[15] && out_ext == ent[13], req,
            {30'd0, out_swap, out_ext}, {30'd0, ~ent[15], ent[13]});
      check(out_lane == exp_lanes(ent, by, a[0]), req, 32'(out_lane),
            32'(exp_lanes(ent, by, a[0])));
      check(out_wdata == ew, req, 32'(out_wdata), 32'(ew));
   endtask

   task automatic t_reset();
      check(out_valid == 1'b0, "R1 valid low", 32'(out_valid), 32'd0);
      map_read(10'd0, "R1 entry 0");
      map_read(10'd1023, "R1 entry 1023");
      map_read(10'd517, "R1 entry 517");
      xlate(24'hABCDEF, 1'b0, 1'b0, 16'h1234, "R1 untouched entry");
      @(negedge clk);
      check(out_valid == 1'b0, "R2 idle after request", 32'(out_valid), 32'd0);
   endtask

   task automatic t_basic();
      map_write(10'd3, 16'hA0A5);
      xlate({4'h0, 10'd3, 10'h155}, 1'b0, 1'b0, 16'hBEEF, "R4 R5 R7 basic");
      map_write(10'd4, 16'h0011);
      xlate({4'h0, 10'd4, 10'h2AA}, 1'b0, 1'b0, 16'hBEEF, "R6 little order swap");
   endtask

   task automatic t_ignore_top();
      xlate({4'hF, 10'd3, 10'h0C3}, 1'b0, 1'b0, 16'h0102, "R3 top F");
      xlate({4'h7, 10'd3, 10'h0C3}, 1'b1, 1'b0, 16'h0102, "R3 top 7");
      xlate({4'h9, 10'd4, 10'h001}, 1'b0, 1'b1, 16'h0102, "R3 top 9");
   endtask

   task automatic t_pfn_high();
      map_write(10'd7, 16'h0F3C);
      xlate({4'h0, 10'd7, 10'h3FF}, 1'b0, 1'b0, 16'h5566, "R5 frame bits 11:8 ignored");
   endtask

   task automatic t_lanes();
      // descriptor 3 big-endian, descriptor 4 little-endian
      xlate({4'h0, 10'd3, 10'h010}, 1'b1, 1'b1, 16'h00AB, "R9 big even");
      xlate({4'h0, 10'd3, 10'h011}, 1'b1, 1'b1, 16'h00AB, "R9 big odd");
      xlate({4'h0, 10'd4, 10'h010}, 1'b1, 1'b1, 16'h00AB, "R9 little even");
      xlate({4'h0, 10'd4, 10'h011}, 1'b0, 1'b1, 16'h00AB, "R9 little odd");
   endtask

   task automatic t_collide();
      // Write and look up descriptor 9 in the same cycle: the old value is used
      @(negedge clk);
      map_we = 1'b1; map_idx = 10'd9; map_wdata = 16'hA077;
      xl_valid = 1'b1; xl_host = 1'b0; xl_byte = 1'b0; xl_addr = {4'h0, 10'd9, 10'h020};
      xl_wdata = 16'h1122;
      @(negedge clk);
      map_we = 1'b0; xl_valid = 1'b0;
      check(out_addr == {8'h00, 10'h020}, "R8 same-cycle uses old", 32'(out_addr),
            32'({8'h00, 10'h020}));
      check(out_ext == 1'b0, "R8 same-cycle old routing", 32'(out_ext), 32'd0);
      shadow[9] = 16'hA077;
      xlate({4'h0, 10'd9, 10'h020}, 1'b0, 1'b0, 16'h1122, "R8 new value next");
      map_read(10'd9, "R8 readback");
      map_write(10'd600, 16'hFFFF);
      map_read(10'd600, "R8 readback all bits");
      map_read(10'd3, "R8 readback other");
   endtask

   task automatic t_top();
      map_write(10'd1023, 16'h8055);
      xlate(24'hFFFFF4, 1'b0, 1'b0, 16'hCAFE, "R10 config pointer controller");
      xlate(24'hFFFFF4, 1'b1, 1'b0, 16'hCAFE, "R10 R2 config pointer host");
      check(out_addr == {8'h55, 10'h3F4}, "R10 address", 32'(out_addr),
            32'({8'h55, 10'h3F4}));
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) shadow[i] = 16'h0000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_ignore_top();
      t_pfn_high();
      t_lanes();
      t_collide();
      t_top();
      repeat (2) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end

endmodule